// File: doc/BRIEF.md
# Shifted-Register Logical Execution Unit

This block is the execute stage for one family of register-to-register logical instructions. Each cycle it can accept a 32-bit instruction word together with two 64-bit operand values, which an external register file has already read. It decodes the word and shifts the second operand by an immediate count using one of four shift kinds. It can then complement that shifted operand, and it combines the result with the first operand by AND, OR or XOR.

The block produces a result value, a destination register index, a write enable, a four-bit condition flag vector with its own update enable, an undefined-encoding indication and a "handled" indication. All outputs are registered. A valid strobe on the input is followed one clock later by a valid strobe on the output.

The instruction word carries a size bit that selects a 32-bit or 64-bit data width. At the narrow width the operands are truncated to 32 bits, the shifts act within 32 bits and the upper half of the result is zero. Register storage, flag storage and exception handling are left to the surrounding pipeline.

Top module: `logic_shift_exu`

## Requirements
- R1: A word is handled only when bits 28:24 equal 01010. An unhandled word gives out_handled=0, out_wr_en=0, out_flag_en=0, out_undef=0 and a zero result, whatever its other bits hold.
- R2: The opcode in bits 30:29 selects the operation: 00 is AND, 01 is OR, 10 is XOR, and 11 is AND with flag update. out_flag_en is 1 only for opcode 11 on a handled, defined word.
- R3: The shift kind in bits 23:22 acts on the second operand only: 00 is logical left, 01 is logical right, 10 is arithmetic right and 11 is rotate right. The count comes from bits 15:10, and at the 64-bit width (bit 31 = 1) every count from 0 to 63 is legal.
- R4: A shift count of 0 leaves the second operand unchanged for all four shift kinds.
- R5: When bit 21 is 1, the shifted second operand is complemented before the logical operation.
- R6: When bit 31 is 0, only bits 31:0 of both operands are used. Arithmetic right shift copies bit 31, rotate right wraps within bits 31:0, and result bits 63:32 are zero.
- R7: When bit 31 is 0 and bit 15 (the top bit of the shift count) is 1 on a handled word, out_undef is 1, out_wr_en and out_flag_en are 0, and the result is zero.
- R8: out_flags holds N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. When out_flag_en is 1, N is the result's top bit at the active width, Z is 1 exactly when the result is zero, and C and V are 0. When out_flag_en is 0, all four flag bits are 0.
- R9: out_dest equals bits 4:0 of the accepted word in every case, including unhandled and undefined words.
- R10: out_valid equals in_valid delayed by one clock. A cycle with in_valid=0 produces out_wr_en, out_flag_en, out_undef and out_handled all 0. Synchronous active-high reset clears every output to 0.
- R11: out_wr_en is 1 exactly for a handled, defined word accepted with in_valid=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 64 | First operand value (register named in bits 9:5) |
| src_b | input | 64 | Second operand value (register named in bits 20:16) |
| out_valid | output | 1 | Registered result is present |
| out_result | output | 64 | Logical result, zero-extended at the 32-bit width |
| out_dest | output | 5 | Destination register index |
| out_wr_en | output | 1 | Destination write request |
| out_flags | output | 4 | Condition flags {N, Z, C, V} |
| out_flag_en | output | 1 | Flag update request |
| out_undef | output | 1 | Undefined encoding detected |
| out_handled | output | 1 | Word belongs to this instruction class |

## Verification
The bench builds the block with its default 64-bit data width, so the narrow path is the 32-bit half-width instance. Random words exercise every opcode, shift kind, invert setting and size with full-range counts. Directed words reach the edges of the shift range: count 0, count 63, rotation across the 32-bit boundary and sign copying from bit 31. They also cover the undefined count at the narrow width, an unhandled word carrying that same count, and flag-setting results that are zero or negative.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

  localparam int XLEN     = 64;
  localparam int HLEN     = XLEN / 2;
  localparam int SHAMT_W  = $clog2(XLEN);
  localparam int HSHAMT_W = $clog2(HLEN);
  localparam int IW       = 32;
  localparam int RIDX_W   = 5;
  localparam int FLAG_W   = 4;

  localparam logic [4:0] CLASS_TAG = 5'b01010;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_XOR  = 2'b10,
    OP_ANDF = 2'b11
  } logic_op_e;

  typedef struct packed {
    logic                handled;
    logic                undef;
    logic                wide;
    logic_op_e           op;
    logic                set_flags;
    shift_kind_e         kind;
    logic                invert;
    logic [SHAMT_W-1:0]  amt;
    logic [RIDX_W-1:0]   rd;
  } decode_t;

  // Bitwise combine for one opcode; the flag-setting variant is an AND.
  function automatic logic [XLEN-1:0] f_combine(input logic_op_e op,
                                                input logic [XLEN-1:0] a,
                                                input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    unique case (op)
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      default: r = a & b;
    endcase
    return r;
  endfunction

  // Clear the bits above the active width.
  function automatic logic [XLEN-1:0] f_width_mask(input logic wide,
                                                   input logic [XLEN-1:0] v);
    return wide ? v : {{HLEN{1'b0}}, v[HLEN-1:0]};
  endfunction

  // Flag vector {N, Z, C, V} for a result at the active width.
  function automatic logic [FLAG_W-1:0] f_flags(input logic wide,
                                                input logic [XLEN-1:0] r);
    logic n;
    logic z;
    n = wide ? r[XLEN-1] : r[HLEN-1];
    z = (r == '0);
    return {n, z, 2'b00};
  endfunction

endpackage

// File: rtl/lsx_decode.sv
module lsx_decode
  import lsx_pkg::*;
(
  input  logic [IW-1:0] instr,
  output decode_t       dec
);

  logic           tag_match;
  logic           narrow_bad;
  logic [1:0]     opc_bits;

  assign tag_match  = (instr[28:24] == CLASS_TAG);
  assign narrow_bad = ~instr[31] & instr[15];
  assign opc_bits   = instr[30:29];

  always_comb begin
    dec.handled   = tag_match;
    dec.undef     = tag_match & narrow_bad;
    dec.wide      = instr[31];
    dec.op        = logic_op_e'(opc_bits);
    dec.set_flags = (opc_bits == 2'b11);
    dec.kind      = shift_kind_e'(instr[23:22]);
    dec.invert    = instr[21];
    dec.amt       = instr[15:10];
    dec.rd        = instr[4:0];
  end

endmodule

// File: rtl/lsx_shifter.sv
module lsx_shifter
  import lsx_pkg::*;
#(
  parameter int W   = 64,
  localparam int AW = $clog2(W)
) (
  input  shift_kind_e   kind,
  input  logic [AW-1:0] amt,
  input  logic [W-1:0]  src,
  output logic [W-1:0]  dst
);

  logic [AW:0]  back_amt;
  logic [W-1:0] rot_hi;
  logic [W-1:0] rot_lo;

  // Wrap-around distance for rotation; equals W when amt is 0, which
  // turns the wrapped part into zero and leaves src unchanged.
  assign back_amt = (AW + 1)'(W) - {1'b0, amt};
  assign rot_hi   = src >> amt;
  assign rot_lo   = src << back_amt;

  always_comb begin
    unique case (kind)
      SK_LSL:  dst = src << amt;
      SK_LSR:  dst = src >> amt;
      SK_ASR:  dst = W'($signed(src) >>> amt);
      default: dst = rot_hi | rot_lo;
    endcase
  end

endmodule

// File: rtl/lsx_logic_flags.sv
module lsx_logic_flags
  import lsx_pkg::*;
(
  input  decode_t            dec,
  input  logic [XLEN-1:0]    op_a,
  input  logic [XLEN-1:0]    op_b_shifted,
  output logic [XLEN-1:0]    result,
  output logic [FLAG_W-1:0]  flags,
  output logic               write_ok,
  output logic               flag_ok
);

  logic [XLEN-1:0] a_w;
  logic [XLEN-1:0] b_inv;
  logic [XLEN-1:0] b_w;
  logic [XLEN-1:0] raw;

  assign write_ok = dec.handled & ~dec.undef;
  assign flag_ok  = write_ok & dec.set_flags;

  assign a_w   = f_width_mask(dec.wide, op_a);
  assign b_inv = dec.invert ? ~op_b_shifted : op_b_shifted;
  assign b_w   = f_width_mask(dec.wide, b_inv);
  assign raw   = f_combine(dec.op, a_w, b_w);

  assign result = write_ok ? raw : '0;
  assign flags  = flag_ok ? f_flags(dec.wide, raw) : '0;

endmodule

// File: rtl/logic_shift_exu.sv
module logic_shift_exu
  import lsx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [63:0]       src_a,
  input  logic [63:0]       src_b,
  output logic              out_valid,
  output logic [63:0]       out_result,
  output logic [4:0]        out_dest,
  output logic              out_wr_en,
  output logic [3:0]        out_flags,
  output logic              out_flag_en,
  output logic              out_undef,
  output logic              out_handled
);

  decode_t          dec;
  logic [XLEN-1:0]  sh_full;
  logic [HLEN-1:0]  sh_half;
  logic [XLEN-1:0]  op_b_shifted;
  logic [XLEN-1:0]  exec_result;
  logic [FLAG_W-1:0] exec_flags;
  logic             exec_write;
  logic             exec_flag;
  logic             exec_undef;
  logic             exec_handled;

  lsx_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  // One shifter per data width; the size bit picks between them.
  localparam int NWIDTH = 2;
  for (genvar g = 0; g < NWIDTH; g++) begin : g_shift
    if (g == 0) begin : g_full
      lsx_shifter #(.W(XLEN)) u_sh (
        .kind (dec.kind),
        .amt  (dec.amt),
        .src  (src_b),
        .dst  (sh_full)
      );
    end else begin : g_half
      lsx_shifter #(.W(HLEN)) u_sh (
        .kind (dec.kind),
        .amt  (dec.amt[HSHAMT_W-1:0]),
        .src  (src_b[HLEN-1:0]),
        .dst  (sh_half)
      );
    end
  end

  assign op_b_shifted = dec.wide ? sh_full : {{HLEN{1'b0}}, sh_half};

  lsx_logic_flags u_logic (
    .dec          (dec),
    .op_a         (src_a),
    .op_b_shifted (op_b_shifted),
    .result       (exec_result),
    .flags        (exec_flags),
    .write_ok     (exec_write),
    .flag_ok      (exec_flag)
  );

  assign exec_undef   = dec.undef;
  assign exec_handled = dec.handled;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_dest    <= '0;
      out_wr_en   <= 1'b0;
      out_flags   <= '0;
      out_flag_en <= 1'b0;
      out_undef   <= 1'b0;
      out_handled <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= exec_result;
        out_dest    <= dec.rd;
        out_wr_en   <= exec_write;
        out_flags   <= exec_flags;
        out_flag_en <= exec_flag;
        out_undef   <= exec_undef;
        out_handled <= exec_handled;
      end else begin
        out_wr_en   <= 1'b0;
        out_flags   <= '0;
        out_flag_en <= 1'b0;
        out_undef   <= 1'b0;
        out_handled <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lsx_exu_chk.sv
module lsx_exu_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic        out_valid,
  input logic [63:0] out_result,
  input logic [4:0]  out_dest,
  input logic        out_wr_en,
  input logic [3:0]  out_flags,
  input logic        out_flag_en,
  input logic        out_undef,
  input logic        out_handled
);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_wr_en && !out_flag_en && !out_undef));

  // R9
  dest_pass_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_dest == $past(instr[4:0])));

  // R7
  undef_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> (!out_wr_en && !out_flag_en && out_handled));

  // R1
  unhandled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_handled) |-> (!out_wr_en && !out_undef && !out_flag_en));

  // R2
  flag_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    out_flag_en |-> out_wr_en);

  // R8
  cv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    out_flags[1:0] == 2'b00);

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_flag_en |-> (out_flags[2] == (out_result == 64'd0)));

  // R6
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !instr[31]) |=> (out_result[63:32] == 32'd0));

endmodule

bind logic_shift_exu lsx_exu_chk u_lsx_exu_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .instr       (instr),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_dest    (out_dest),
  .out_wr_en   (out_wr_en),
  .out_flags   (out_flags),
  .out_flag_en (out_flag_en),
  .out_undef   (out_undef),
  .out_handled (out_handled)
);

// File: tb/test_logic_shift_exu.sv
module test_logic_shift_exu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic [4:0]  out_dest;
  logic        out_wr_en;
  logic [3:0]  out_flags;
  logic        out_flag_en;
  logic        out_undef;
  logic        out_handled;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  logic_shift_exu i_logic_shift_exu (
    .clk, .rst, .in_valid, .instr, .src_a, .src_b,
    .out_valid, .out_result, .out_dest, .out_wr_en,
    .out_flags, .out_flag_en, .out_undef, .out_handled
  );

  function automatic logic [31:0] enc(input logic sf, input logic [1:0] opc,
                                      input logic [1:0] kind, input logic inv,
                                      input logic [5:0] amt, input logic [4:0] rd);
    return {sf, opc, 5'b01010, kind, inv, 5'd3, amt, 5'd7, rd};
  endfunction

  // Expected {handled, undef, wr, flag_en, flags[3:0], dest[4:0], result[63:0]}
  function automatic logic [76:0] model(input logic [31:0] w,
                                        input logic [63:0] a, input logic [63:0] b);
    logic hd, ud, wr, fe;
    logic [3:0] fl;
    logic [63:0] sb, ar, r;
    int wd, amt, j;
    hd = (w[28:24] == 5'b01010);
    wd = w[31] ? 64 : 32;
    amt = int'(w[15:10]);
    ud = hd && !w[31] && w[15];
    wr = hd && !ud;
    sb = '0;
    ar = '0;
    for (int i = 0; i < wd; i++) begin
      ar[i] = a[i];
      case (w[23:22])
        2'b00: begin j = i - amt; sb[i] = (j >= 0) ? b[j] : 1'b0; end
        2'b01: begin j = i + amt; sb[i] = (j < wd) ? b[j] : 1'b0; end
        2'b10: begin j = i + amt; sb[i] = (j < wd) ? b[j] : b[wd-1]; end
        default: sb[i] = b[(i + amt) % wd];
      endcase
      if (w[21]) sb[i] = ~sb[i];
    end
    case (w[30:29])
      2'b01:   r = ar | sb;
      2'b10:   r = ar ^ sb;
      default: r = ar & sb;
    endcase
    if (!wr) r = '0;
    fe = wr && (w[30:29] == 2'b11);
    fl = fe ? {r[wd-1], (r == 64'd0), 2'b00} : 4'b0000;
    return {hd, ud, wr, fe, fl, w[4:0], r};
  endfunction

  task automatic check(input string tag, input logic [76:0] exp_v);
    logic [76:0] act;
    act = {out_handled, out_undef, out_wr_en, out_flag_en, out_flags, out_dest, out_result};
    checks++;
    if (!out_valid || act !== exp_v) begin
      failures++;
      $display("FAIL %s valid=%0b actual=%h expected=%h", tag, out_valid, act, exp_v);
    end
  endtask

  // Drive at a falling edge; the output register loads on the next rising
  // edge and is sampled at the following falling edge.
  task automatic run(input string tag, input logic [31:0] w,
                     input logic [63:0] a, input logic [63:0] b);
    instr = w; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    check(tag, model(w, a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (out_valid || out_wr_en || out_flag_en || out_undef || out_handled ||
        out_result != 0 || out_flags != 0 || out_dest != 0) begin
      failures++;
      $display("FAIL R10 reset state actual=%b%b%b expected=000", out_valid, out_wr_en, out_undef);
    end
    rst = 1'b0;
    @(negedge clk);

    // R4 zero count for every kind, both widths
    for (int k = 0; k < 4; k++) begin
      run("R4 zero count wide", enc(1'b1, 2'b00, 2'(k), 1'b0, 6'd0, 5'd1),
          64'hFFFF_FFFF_FFFF_FFFF, 64'h8123_4567_89AB_CDEF);
      run("R4 zero count narrow", enc(1'b0, 2'b01, 2'(k), 1'b0, 6'd0, 5'd2),
          64'h0, 64'hFEDC_BA98_8765_4321);
    end
    // R3 extreme counts at the wide width
    run("R3 lsl 63", enc(1'b1, 2'b01, 2'b00, 1'b0, 6'd63, 5'd4), 64'h0, 64'h1);
    run("R3 lsr 63", enc(1'b1, 2'b01, 2'b01, 1'b0, 6'd63, 5'd4), 64'h0, 64'h8000_0000_0000_0000);
    run("R3 asr 40", enc(1'b1, 2'b01, 2'b10, 1'b0, 6'd40, 5'd4), 64'h0, 64'h8000_0000_0000_0000);
    run("R3 ror 33", enc(1'b1, 2'b10, 2'b11, 1'b0, 6'd33, 5'd4), 64'h5, 64'h0000_0001_0000_0003);
    // R6 narrow semantics
    run("R6 asr copies bit31", enc(1'b0, 2'b01, 2'b10, 1'b0, 6'd4, 5'd5),
        64'h0, 64'h0000_0000_8000_0000);
    run("R6 ror wraps in 32", enc(1'b0, 2'b01, 2'b11, 1'b0, 6'd8, 5'd5),
        64'hFFFF_0000_0000_0000, 64'hFFFF_FFFF_1234_56AB);
    run("R6 upper cleared", enc(1'b0, 2'b00, 2'b00, 1'b1, 6'd31, 5'd5),
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    // R5 invert with XOR
    run("R5 invert xor", enc(1'b1, 2'b10, 2'b01, 1'b1, 6'd12, 5'd6),
        64'h0F0F_0F0F_0F0F_0F0F, 64'h1234_5678_9ABC_DEF0);
    // R8 flags: zero result and negative narrow result
    run("R8 zero flag", enc(1'b1, 2'b11, 2'b00, 1'b0, 6'd0, 5'd8),
        64'hFF00, 64'h00FF);
    run("R8 negative narrow", enc(1'b0, 2'b11, 2'b00, 1'b0, 6'd0, 5'd8),
        64'h0000_0000_8000_0001, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R2 or no flags", enc(1'b1, 2'b01, 2'b00, 1'b0, 6'd0, 5'd9), 64'h0, 64'h8000_0000_0000_0000);
    // R7 undefined narrow count
    run("R7 undefined count", enc(1'b0, 2'b00, 2'b00, 1'b0, 6'd32, 5'd10),
        64'hFFFF, 64'hFFFF);
    // R1 unhandled word carrying the same bad count
    run("R1 unhandled", {1'b0, 2'b11, 5'b01011, 2'b00, 1'b0, 5'd3, 6'd32, 5'd7, 5'd11},
        64'hFFFF, 64'hFFFF);
    // R10 idle cycle
    in_valid = 1'b0;
    instr = enc(1'b1, 2'b11, 2'b00, 1'b0, 6'd0, 5'd12);
    @(negedge clk);
    checks++;
    if (out_valid || out_wr_en || out_flag_en || out_undef || out_handled) begin
      failures++;
      $display("FAIL R10 idle actual=%b%b%b%b%b expected=00000",
               out_valid, out_wr_en, out_flag_en, out_undef, out_handled);
    end

    // R2 R3 R9 R11 random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] w;
      logic [63:0] a, b;
      w = $urandom;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (($urandom % 10) != 0) w[28:24] = 5'b01010;
      if (!w[31] && ($urandom % 6) != 0) w[15] = 1'b0;
      run("R11 random", w, a, b);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule